// File: doc/BRIEF.md
# Multi-Gain Sample Selector with Idle Compression

This block sits behind three 8-bit converters that sample one analog signal at low, medium and high gain. Every core clock it receives a group of four consecutive samples from each converter. It forwards one channel per group: the channel with the highest gain that has no sample stuck at a rail. Each output word carries a 2-bit header, so the receiving end knows which gain to undo when it rebuilds the waveform.

While the selected samples stay close to a programmable baseline, the block sends a short word instead. This word holds only the low four bits of each high-gain sample, taken relative to the baseline, so a group needs 16 payload bits instead of 32. Once a sample moves past the threshold, full words are sent. They keep being sent for a programmable number of further groups. Two events use an escape word in the same stream: a pulse from the timestamp counter when it wraps, and a report that groups were lost to a full buffer. An in-order buffer evens out bursts before a valid/ready output.

Top module: `mgs_top`

## Requirements
- R1: A channel counts as railed when any of its four samples equals 0x00 or 0xFF. The selector takes the high-gain channel if it is not railed. Otherwise it takes the mid-gain channel if that is not railed. Otherwise it takes the low-gain channel.
- R2: A full word is {header, group}. The header is 2'b01 for low gain, 2'b10 for mid gain and 2'b11 for high gain. Lane i of the selected group sits in payload bits [8i+7:8i].
- R3: A group is sent as a full word when any selected sample differs from cfg_base by more than cfg_thresh. The difference is an absolute difference.
- R4: After the last triggering group, the next cfg_hold groups are still sent as full words. The group after those is compressed again.
- R5: A compressed word has header 2'b00 and payload bit 31 clear. Bits [4i+3:4i] hold (high-gain lane i minus cfg_base) modulo 16. All other payload bits are zero.
- R6: A ts_wrap pulse produces an event word: header 2'b00, payload bit 31 set and payload bit 0 set. If a group is presented in the same cycle as the pulse, the event word comes before that group's word.
- R7: When the buffer has no room, the group is dropped and a sticky lost-data flag is set. Once a slot frees, an event word with payload bit 31 and bit 1 set is queued. It comes after every word that was already buffered.
- R8: Words leave in the order they were produced. While out_valid is high and out_ready is low, out_word does not change.
- R9: After reset, out_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A group of four samples is present on all three channels |
| in_lo | input | 32 | Low-gain group, lane i in bits [8i+7:8i] |
| in_mid | input | 32 | Mid-gain group |
| in_hi | input | 32 | High-gain group |
| cfg_base | input | 8 | Baseline code |
| cfg_thresh | input | 8 | Trigger threshold (absolute difference) |
| cfg_hold | input | 8 | Number of groups kept in full format after the last trigger |
| ts_wrap | input | 1 | One-cycle pulse when the timestamp counter wraps |
| out_ready | input | 1 | Downstream accepts a word |
| out_valid | output | 1 | A word is available |
| out_word | output | 34 | Header in bits [33:32], payload in bits [31:0] |

## Verification
The assertions assume that cfg_base, cfg_thresh and cfg_hold are held constant while groups are flowing. They also assume that ts_wrap is a pulse and that two event causes are never pending unreported at once, because pending causes merge into one event word. The stimulus changes configuration only before streaming starts. It fires ts_wrap with the buffer partly drained and never during the fill-to-overflow sequence. It paces the random traffic so that output capacity stays above the input rate, which means the only groups lost are the ones the overflow test drops on purpose.

// File: rtl/mgs_pkg.sv
package mgs_pkg;
  typedef enum logic [1:0] {
    HDR_PACK = 2'b00,
    HDR_LO   = 2'b01,
    HDR_MID  = 2'b10,
    HDR_HI   = 2'b11
  } hdr_e;

  localparam int DEF_SW     = 8;
  localparam int DEF_LANES  = 4;
  localparam int DEF_NIB    = 4;
  localparam int DEF_DEPTH  = 16;
  localparam int DEF_HOLD_W = 8;

  localparam int EV_TS_BIT  = 0;
  localparam int EV_OVF_BIT = 1;
endpackage

// File: rtl/mgs_gain_pick.sv
module mgs_gain_pick
  import mgs_pkg::*;
#(
  parameter int SW    = DEF_SW,
  parameter int LANES = DEF_LANES,
  localparam int GW   = SW * LANES
) (
  input  logic [GW-1:0] grp_lo,
  input  logic [GW-1:0] grp_mid,
  input  logic [GW-1:0] grp_hi,
  output hdr_e          pick,
  output logic [GW-1:0] pick_grp,
  output logic          rail_hi,
  output logic          rail_mid
);
  logic [LANES-1:0] lane_rail_hi, lane_rail_mid;

  function automatic logic at_rail(input logic [SW-1:0] s);
    return (s == '0) || (s == '1);
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_rail_hi[i]  = at_rail(grp_hi[i*SW +: SW]);
    assign lane_rail_mid[i] = at_rail(grp_mid[i*SW +: SW]);
  end

  assign rail_hi  = |lane_rail_hi;
  assign rail_mid = |lane_rail_mid;

  always_comb begin
    if (!rail_hi) begin
      pick     = HDR_HI;
      pick_grp = grp_hi;
    end else if (!rail_mid) begin
      pick     = HDR_MID;
      pick_grp = grp_mid;
    end else begin
      pick     = HDR_LO;
      pick_grp = grp_lo;
    end
  end
endmodule

// File: rtl/mgs_activity.sv
module mgs_activity
  import mgs_pkg::*;
#(
  parameter int SW     = DEF_SW,
  parameter int LANES  = DEF_LANES,
  parameter int HOLD_W = DEF_HOLD_W,
  localparam int GW    = SW * LANES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              grp_valid,
  input  logic [GW-1:0]     grp,
  input  logic [SW-1:0]     base,
  input  logic [SW-1:0]     thresh,
  input  logic [HOLD_W-1:0] hold,
  output logic              trig,
  output logic              active
);
  logic [LANES-1:0]  lane_over;
  logic [HOLD_W-1:0] hold_cnt;

  function automatic logic [SW-1:0] gap(input logic [SW-1:0] a, input logic [SW-1:0] b);
    return (a > b) ? (a - b) : (b - a);
  endfunction

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_over[i] = gap(grp[i*SW +: SW], base) > thresh;
  end

  assign trig   = grp_valid && (|lane_over);
  assign active = trig || (hold_cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hold_cnt <= '0;
    end else if (grp_valid) begin
      if (trig)                hold_cnt <= hold;
      else if (hold_cnt != '0) hold_cnt <= hold_cnt - 1'b1;
    end
  end

  // R4: a trigger with a nonzero hold keeps the next group in full format
  p_hold_armed_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (trig && hold != '0) |=> active || !grp_valid);
endmodule

// File: rtl/mgs_fifo.sv
module mgs_fifo
  import mgs_pkg::*;
#(
  parameter int W     = 34,
  parameter int DEPTH = DEF_DEPTH,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    wr_n,
  input  logic [W-1:0]  wr_d0,
  input  logic [W-1:0]  wr_d1,
  input  logic          rd_ready,
  output logic          rd_valid,
  output logic [W-1:0]  rd_data,
  output logic [CW-1:0] free_slots
);
  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          pop;

  assign rd_valid   = cnt != '0;
  assign rd_data    = mem[rp];
  assign pop        = rd_valid && rd_ready;
  assign free_slots = CW'(DEPTH) - cnt;

  always_ff @(posedge clk) begin
    if (wr_n != 2'd0) mem[wp] <= wr_d0;
    if (wr_n == 2'd2) mem[wp + AW'(1)] <= wr_d1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      wp  <= wp + AW'(wr_n);
      rp  <= rp + AW'(pop);
      cnt <= cnt + CW'(wr_n) - CW'(pop);
    end
  end

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));
  p_write_fits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    CW'(wr_n) <= free_slots);
endmodule

// File: rtl/mgs_top.sv
module mgs_top
  import mgs_pkg::*;
#(
  parameter int SW     = DEF_SW,
  parameter int LANES  = DEF_LANES,
  parameter int NIB    = DEF_NIB,
  parameter int DEPTH  = DEF_DEPTH,
  parameter int HOLD_W = DEF_HOLD_W,
  localparam int GW     = SW * LANES,
  localparam int WORD_W = GW + 2,
  localparam int CW     = $clog2(DEPTH) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [GW-1:0]     in_lo,
  input  logic [GW-1:0]     in_mid,
  input  logic [GW-1:0]     in_hi,
  input  logic [SW-1:0]     cfg_base,
  input  logic [SW-1:0]     cfg_thresh,
  input  logic [HOLD_W-1:0] cfg_hold,
  input  logic              ts_wrap,
  input  logic              out_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_word
);
  hdr_e              pick;
  logic [GW-1:0]     pick_grp;
  logic              rail_hi, rail_mid;
  logic              trig, active;
  logic              s1_valid;
  logic [WORD_W-1:0] s1_word;
  logic [1:0]        ev_flags;
  logic [WORD_W-1:0] ev_word;
  logic [CW-1:0]     free_slots;
  logic              ev_wr, data_wr, drop;
  logic [1:0]        wr_n;
  logic [WORD_W-1:0] wr_d0;

  function automatic logic [GW-2:0] squeeze(input logic [GW-1:0] g, input logic [SW-1:0] b);
    logic [GW-2:0] r;
    logic [SW-1:0] d;
    r = '0;
    for (int i = 0; i < LANES; i++) begin
      d = g[i*SW +: SW] - b;
      r[i*NIB +: NIB] = d[NIB-1:0];
    end
    return r;
  endfunction

  function automatic logic any_rail(input logic [GW-1:0] g);
    logic r;
    r = 1'b0;
    for (int i = 0; i < LANES; i++)
      if (g[i*SW +: SW] == '0 || g[i*SW +: SW] == '1) r = 1'b1;
    return r;
  endfunction

  mgs_gain_pick #(.SW(SW), .LANES(LANES)) u_pick (
    .grp_lo(in_lo), .grp_mid(in_mid), .grp_hi(in_hi),
    .pick(pick), .pick_grp(pick_grp), .rail_hi(rail_hi), .rail_mid(rail_mid)
  );

  mgs_activity #(.SW(SW), .LANES(LANES), .HOLD_W(HOLD_W)) u_act (
    .clk(clk), .rst_n(rst_n), .grp_valid(in_valid), .grp(pick_grp),
    .base(cfg_base), .thresh(cfg_thresh), .hold(cfg_hold),
    .trig(trig), .active(active)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_word  <= '0;
    end else begin
      s1_valid <= in_valid;
      if (in_valid)
        s1_word <= active ? {pick, pick_grp}
                          : {HDR_PACK, 1'b0, squeeze(in_hi, cfg_base)};
    end
  end

  assign ev_word = {HDR_PACK, 1'b1, {(GW-3){1'b0}}, ev_flags};
  assign ev_wr   = (ev_flags != 2'b00) && (free_slots != '0);
  assign data_wr = s1_valid && (free_slots > CW'(ev_wr));
  assign drop    = s1_valid && !data_wr;
  assign wr_n    = {1'b0, ev_wr} + {1'b0, data_wr};
  assign wr_d0   = ev_wr ? ev_word : s1_word;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ev_flags <= 2'b00;
    end else begin
      ev_flags <= (ev_wr ? 2'b00 : ev_flags)
                | (2'(drop) << EV_OVF_BIT) | (2'(ts_wrap) << EV_TS_BIT);
    end
  end

  mgs_fifo #(.W(WORD_W), .DEPTH(DEPTH)) u_fifo (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .wr_d0(wr_d0), .wr_d1(s1_word),
    .rd_ready(out_ready), .rd_valid(out_valid), .rd_data(out_word),
    .free_slots(free_slots)
  );

  // R8: a stalled word holds still
  p_stall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_word)));
  // R7: a dropped group leaves the lost-data flag pending
  p_drop_flags_r7: assert property (@(posedge clk) disable iff (!rst_n)
    drop |=> ev_flags[EV_OVF_BIT]);
  // R1: a high-gain full word never came from a railed high-gain group
  p_hi_clean_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && pick == HDR_HI) |=> !any_rail($past(in_hi)));
  // R6: a timestamp pulse is pending on the next cycle
  p_ts_pending_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ts_wrap |=> ev_flags[EV_TS_BIT]);
endmodule

// File: tb/tb_mgs_top.sv
module tb_mgs_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [31:0] in_lo = '0, in_mid = '0, in_hi = '0;
  logic [7:0]  cfg_base = 8'd128, cfg_thresh = 8'd10, cfg_hold = 8'd2;
  logic        ts_wrap = 1'b0;
  logic        out_ready = 1'b0;
  logic        out_valid;
  logic [33:0] out_word;

  int unsigned total = 0, failed = 0, cyc = 0;
  int          ready_mode = 0;
  int          m_cnt = 0;
  logic [33:0] expq[$];
  string       tagq[$];

  mgs_top dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_lo(in_lo), .in_mid(in_mid),
    .in_hi(in_hi), .cfg_base(cfg_base), .cfg_thresh(cfg_thresh), .cfg_hold(cfg_hold),
    .ts_wrap(ts_wrap), .out_ready(out_ready), .out_valid(out_valid), .out_word(out_word)
  );

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    #1;
    case (ready_mode)
      0: out_ready = 1'b0;
      1: out_ready = 1'b1;
      default: out_ready = (cyc % 4) != 0;
    endcase
  end

  task automatic check(input bit ok, input string tag, input logic [33:0] act, input logic [33:0] exp);
    total++;
    if (!ok) begin
      failed++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: a transfer happens at the next rising edge
  always @(negedge clk) begin
    if (rst_n && out_valid && out_ready) begin
      if (expq.size() == 0) check(1'b0, "R8 unexpected word", out_word, 34'h0);
      else begin
        logic [33:0] e;
        string t;
        e = expq.pop_front();
        t = tagq.pop_front();
        check(out_word === e, t, out_word, e);
      end
    end
  end

  function automatic bit railed(input logic [31:0] g);
    for (int i = 0; i < 4; i++) begin
      logic [7:0] b;
      b = g[8*i +: 8];
      if (b == 8'h00 || b == 8'hff) return 1'b1;
    end
    return 1'b0;
  endfunction

  task automatic push(input logic [33:0] w, input string t);
    expq.push_back(w);
    tagq.push_back(t);
  endtask

  task automatic send(input logic [31:0] lo, mid, hi, input bit ts, input bit keep, input string tag);
    logic [1:0]  h;
    logic [31:0] s, nz;
    bit          hit;
    if (!railed(hi))       begin h = 2'b11; s = hi;  end
    else if (!railed(mid)) begin h = 2'b10; s = mid; end
    else                   begin h = 2'b01; s = lo;  end
    hit = 1'b0;
    for (int i = 0; i < 4; i++) begin
      int d;
      d = int'(s[8*i +: 8]) - int'(cfg_base);
      if (d < 0) d = -d;
      if (d > int'(cfg_thresh)) hit = 1'b1;
    end
    nz = '0;
    for (int i = 0; i < 4; i++) begin
      int d;
      d = (int'(hi[8*i +: 8]) - int'(cfg_base)) & 15;
      nz[4*i +: 4] = d[3:0];
    end
    if (ts) push({2'b00, 32'h8000_0001}, "R6 timestamp event");
    if (keep) begin
      if (hit || m_cnt > 0) push({h, s}, tag);
      else                  push({2'b00, nz}, tag);
    end
    if (hit) m_cnt = int'(cfg_hold);
    else if (m_cnt > 0) m_cnt--;
    in_lo = lo; in_mid = mid; in_hi = hi; ts_wrap = ts; in_valid = 1'b1;
    @(posedge clk); #1;
    in_valid = 1'b0; ts_wrap = 1'b0;
  endtask

  task automatic drain();
    for (int k = 0; k < 400 && expq.size() != 0; k++) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++; failed++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end

  initial begin
    logic [31:0] lf;
    logic [33:0] w0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    check(out_valid === 1'b0, "R9 reset idle", {33'b0, out_valid}, 34'h0);
    ready_mode = 1;
    @(posedge clk); #1;

    // R5 quiet group: compressed nibbles of high-gain minus baseline
    send(32'h80808080, 32'h80808080, 32'h877e8083, 0, 1, "R5 compressed");
    // R3 trigger on high gain, R4 two held groups, then compressed again
    send(32'h80808080, 32'h80808080, 32'h80a08080, 0, 1, "R3 trigger full hi");
    send(32'h80808080, 32'h80808080, 32'h81808080, 0, 1, "R4 hold first");
    send(32'h80808080, 32'h80808080, 32'h80818080, 0, 1, "R4 hold second");
    send(32'h80808080, 32'h80808080, 32'h80808180, 0, 1, "R4 hold expired");
    // R1 selection order and R2 header codes
    send(32'h10203040, 32'h20406080, 32'h40ff8080, 0, 1, "R1 R2 mid on hi rail");
    send(32'h10203040, 32'h00406080, 32'h4080ff80, 0, 1, "R1 R2 lo on both rails");
    send(32'h10203040, 32'h204060ff, 32'h00808080, 0, 1, "R1 lo on hi zero");
    send(32'h10203040, 32'h20406080, 32'h90808080, 0, 1, "R2 hi full");
    drain();
    // R6 timestamp event alone and together with a group
    ts_wrap = 1'b1; push({2'b00, 32'h8000_0001}, "R6 lone timestamp");
    @(posedge clk); #1 ts_wrap = 1'b0;
    repeat (3) @(posedge clk); #1;
    send(32'h80808080, 32'h80808080, 32'h80808082, 1, 1, "R6 group after event");
    drain();

    // R8 random traffic with stalls
    ready_mode = 2;
    lf = 32'h1bad5eed;
    for (int n = 0; n < 200; n++) begin
      logic [31:0] a, b, c;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]}; a = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]}; b = lf;
      lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]}; c = lf;
      if (n % 3 == 0) c = {c[31:8] & 24'h0f0f0f | 24'h787878, 8'h80};
      if (n % 7 == 0) c[15:8] = 8'hff;
      if (n % 11 == 0) b[7:0] = 8'h00;
      send(a, b, c, 0, 1, "R8 random order");
      @(posedge clk); #1;
    end
    ready_mode = 1;
    drain();

    // R7 overflow: buffer fills, three groups lost, event reported after
    ready_mode = 0;
    repeat (2) @(posedge clk); #1;
    for (int n = 0; n < 19; n++)
      send(32'h80808080, 32'h80808080, {8'h80, 8'h80, 8'h80, 8'(8'h70 + n)}, 0, n < 16, "R7 buffered before loss");
    repeat (3) @(posedge clk);
    @(negedge clk);
    w0 = out_word;
    check(out_valid === 1'b1 && w0 === expq[0], "R8 stalled head", w0, expq[0]);
    repeat (4) @(posedge clk);
    @(negedge clk);
    check(out_word === w0, "R8 stable under stall", out_word, w0);
    push({2'b00, 32'h8000_0002}, "R7 lost-data event");
    @(posedge clk); #1;
    ready_mode = 1;
    drain();

    check(expq.size() == 0, "R8 all words delivered", 34'(expq.size()), 34'h0);
    @(negedge clk);
    check(out_valid === 1'b0, "R7 no extra words", {33'b0, out_valid}, 34'h0);
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule